// File: doc/BRIEF.md
# Smart Card Character Framer

This block moves single characters over a half-duplex, open-drain serial line of the kind used by contact smart cards. Software programs a small register bank and writes a byte into a transmit holding register. The block then sends a frame: a low start bit, eight data bits and a parity bit, with each bit lasting a fixed number of sampling ticks. When the block is not transmitting, it watches the same line for a falling edge. It qualifies the start bit at mid-bit, samples the nine following bits at their centres and leaves the rebuilt byte in a receive register. The parity check result goes to a status bit.

Two independent controls in the mode register select the character convention. One control picks the bit order on the line, the other inverts the data bits. Either control acts in both directions. Inversion never touches the parity bit. Parity always covers the byte as software sees it in the data registers, and a control bit picks even or odd sense, so software chooses the sense that matches the convention in force. The line is pulled up externally: the block only ever drives it low.

Register map (2-bit address): 0 = mode, 1 = transmit data (write), 2 = receive data (read), 3 = control/status. In the control/status register, bit 0 selects odd parity (read/write), bit 1 is the parity error of the last received frame, bit 2 means a received byte is waiting, bit 3 means a frame is being sent, and bit 4 means a transmit byte is held. Bits 7..5 read 0.

Top module: `sc_framer`

## Requirements
- R1: After reset the mode register reads 0xF2, control/status bits 4..0 read 0 and the line is not driven low.
- R2: Mode bits 7..4 and bit 1 always read 1 whatever is written. Bit 3 (bit order), bit 2 (data invert) and bit 0 (enable) are read/write.
- R3: A cycle with `standby_i` high returns the mode register to 0xF2 and clears the control/status bits and any frame in progress.
- R4: A transmit frame drives a low start bit, then 8 data bits, then the parity bit. Each bit lasts OVS sampling ticks. The line is released (not driven) whenever no frame is in progress, and a 1 bit is sent by releasing it.
- R5: With mode bit 3 = 0, data goes out and is rebuilt least significant bit first. With mode bit 3 = 1, the most significant bit comes first, in both directions.
- R6: With mode bit 2 = 1, the transmit byte is inverted before it goes on the line, and the received bits are inverted before they are stored. With bit 2 = 0, the data passes unchanged.
- R7: The parity bit equals the XOR of the register-side byte XOR control bit 0 (0 = even, 1 = odd). It is never inverted by mode bit 2.
- R8: A receive frame (falling edge, low at mid start bit) stores the byte in register 2 and sets status bit 2. A read of register 2 clears status bit 2.
- R9: Status bit 1 is 1 when the parity bit of the last received frame did not match R7, and 0 when it did.
- R10: A byte written to register 1 while a frame is being sent is held (status bit 4 = 1). It is sent as the next frame after the current one ends, with no change to the current frame.
- R11: With mode bit 0 = 0, no transmit frame starts (a written byte stays held) and the receiver ignores the line. Setting bit 0 again lets the held byte go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Hardware standby request; resets the block state synchronously |
| sample_tick_i | input | 1 | One-cycle sampling enable, OVS per bit period |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effect on register 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| line_i | input | 1 | Sensed level of the shared serial line |
| line_drive_low_o | output | 1 | Pulls the shared line low when 1 |

## Verification
The bench puts all four order/invert combinations through both directions. A design that inverted the parity bit along with the data, or reversed the order in only one direction, would show a wrong line bit in the transmit comparison or a wrong stored byte or parity flag on receive. It writes a second byte in the middle of a frame: a design that loaded the new byte at once would corrupt the frame on the line. It also writes the fixed mode bits, clears the enable bit with a byte held, and pulses standby with non-default settings in place. These show fixed bits that take writes, frames that start while the block is disabled, and standby that leaves state behind.

// File: rtl/sc_framer_pkg.sv
package sc_framer_pkg;

  localparam int DW = 8;
  localparam logic [7:0] MODE_RESET = 8'hF2;
  localparam logic [7:0] MODE_RW_MASK = 8'h0D;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_TXD  = 2'd1,
    A_RXD  = 2'd2,
    A_CTL  = 2'd3
  } reg_addr_e;

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = d[DW-1-i];
    return r;
  endfunction

  // Maps between register-side byte and line order; self-inverse.
  function automatic logic [DW-1:0] line_map(input logic [DW-1:0] d,
                                             input logic msb, input logic inv);
    logic [DW-1:0] v;
    v = inv ? ~d : d;
    return msb ? flip(v) : v;
  endfunction

endpackage

// File: rtl/sc_regs.sv
module sc_regs
  import sc_framer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic          re,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          tx_take,
  input  logic          tx_busy,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_perr,
  output logic [7:0]    rdata,
  output logic          msb,
  output logic          inv,
  output logic          en,
  output logic          odd,
  output logic [DW-1:0] thr,
  output logic          thr_full
);

  logic [7:0]    mode_q, mode_d;
  logic          odd_q, odd_d;
  logic [DW-1:0] thr_q, thr_d, rdr_q, rdr_d;
  logic          full_q, full_d, rxv_q, rxv_d, perr_q, perr_d;

  always_comb begin
    mode_d = mode_q;
    odd_d  = odd_q;
    thr_d  = thr_q;
    full_d = full_q;
    rdr_d  = rdr_q;
    rxv_d  = rxv_q;
    perr_d = perr_q;
    if (tx_take) full_d = 1'b0;
    if (we) begin
      unique case (reg_addr_e'(addr))
        A_MODE: mode_d = (wdata & MODE_RW_MASK) | (MODE_RESET & ~MODE_RW_MASK);
        A_TXD: begin
          thr_d  = wdata[DW-1:0];
          full_d = 1'b1;
        end
        A_CTL:  odd_d = wdata[0];
        default: ;
      endcase
    end
    if (rx_done) begin
      rdr_d  = rx_byte;
      rxv_d  = 1'b1;
      perr_d = rx_perr;
    end else if (re && reg_addr_e'(addr) == A_RXD) begin
      rxv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      odd_q  <= 1'b0;
      thr_q  <= '0;
      full_q <= 1'b0;
      rdr_q  <= '0;
      rxv_q  <= 1'b0;
      perr_q <= 1'b0;
    end else if (clr) begin
      mode_q <= MODE_RESET;
      odd_q  <= 1'b0;
      thr_q  <= '0;
      full_q <= 1'b0;
      rdr_q  <= '0;
      rxv_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      odd_q  <= odd_d;
      thr_q  <= thr_d;
      full_q <= full_d;
      rdr_q  <= rdr_d;
      rxv_q  <= rxv_d;
      perr_q <= perr_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      A_MODE:  rdata = mode_q;
      A_TXD:   rdata = thr_q;
      A_RXD:   rdata = rdr_q;
      default: rdata = {3'b000, full_q, tx_busy, rxv_q, perr_q, odd_q};
    endcase
  end

  assign msb      = mode_q[3];
  assign inv      = mode_q[2];
  assign en       = mode_q[0];
  assign odd      = odd_q;
  assign thr      = thr_q;
  assign thr_full = full_q;

endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_framer_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          en,
  input  logic          msb,
  input  logic          inv,
  input  logic          odd,
  input  logic          pend,
  input  logic [DW-1:0] data,
  output logic          take,
  output logic          busy,
  output logic          drive_low
);

  localparam int FB = DW + 2;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FB);

  logic [FB-1:0] sh_q, sh_d;
  logic [CW-1:0] tc_q, tc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          busy_q, busy_d;
  logic          par;

  assign par  = (^data) ^ odd;
  assign take = tick && !busy_q && pend && en;

  always_comb begin
    sh_d   = sh_q;
    tc_d   = tc_q;
    bc_d   = bc_q;
    busy_d = busy_q;
    if (take) begin
      sh_d   = {par, line_map(data, msb, inv), 1'b0};
      busy_d = 1'b1;
      tc_d   = '0;
      bc_d   = '0;
    end else if (busy_q && tick) begin
      if (tc_q == CW'(OVS - 1)) begin
        tc_d = '0;
        if (bc_q == BW'(FB - 1)) begin
          busy_d = 1'b0;
        end else begin
          bc_d = bc_q + 1'b1;
          sh_d = {1'b1, sh_q[FB-1:1]};
        end
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
    end else if (clr) begin
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tc_q   <= tc_d;
      bc_q   <= bc_d;
      busy_q <= busy_d;
    end
  end

  assign busy      = busy_q;
  assign drive_low = busy_q & ~sh_q[0];

endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_framer_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          active,
  input  logic          line_i,
  input  logic          msb,
  input  logic          inv,
  input  logic          odd,
  output logic          done,
  output logic [DW-1:0] byte_o,
  output logic          perr
);

  localparam int CW   = $clog2(OVS);
  localparam int NS   = DW + 1;
  localparam int IW   = $clog2(NS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} rx_state_e;

  rx_state_e     st_q, st_d;
  logic [1:0]    sync_q;
  logic          ls, prev_q, prev_d;
  logic [CW-1:0] rc_q, rc_d;
  logic [IW-1:0] ri_q, ri_d;
  logic [NS-1:0] sh_q, sh_d;
  logic          done_d, done_q, perr_d, perr_q;
  logic [DW-1:0] byte_d, byte_q;

  assign ls = sync_q[1];

  always_comb begin
    st_d   = st_q;
    prev_d = tick ? ls : prev_q;
    rc_d   = rc_q;
    ri_d   = ri_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    byte_d = byte_q;
    perr_d = perr_q;
    if (!active) begin
      st_d = S_IDLE;
    end else if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (prev_q && !ls) begin
            st_d = S_START;
            rc_d = '0;
          end
        end
        S_START: begin
          if (rc_q == CW'(HALF - 2)) begin
            rc_d = '0;
            ri_d = '0;
            st_d = ls ? S_IDLE : S_DATA;
          end else begin
            rc_d = rc_q + 1'b1;
          end
        end
        S_DATA: begin
          if (rc_q == CW'(OVS - 1)) begin
            rc_d = '0;
            sh_d = {ls, sh_q[NS-1:1]};
            if (ri_q == IW'(NS - 1)) begin
              st_d   = S_IDLE;
              done_d = 1'b1;
              byte_d = line_map(sh_d[DW-1:0], msb, inv);
              perr_d = sh_d[NS-1] != ((^byte_d) ^ odd);
            end else begin
              ri_d = ri_q + 1'b1;
            end
          end else begin
            rc_d = rc_q + 1'b1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= S_IDLE;
      prev_q <= 1'b1;
      rc_q   <= '0;
      ri_q   <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      byte_q <= '0;
      perr_q <= 1'b0;
    end else if (clr) begin
      sync_q <= 2'b11;
      st_q   <= S_IDLE;
      prev_q <= 1'b1;
      rc_q   <= '0;
      ri_q   <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      byte_q <= '0;
      perr_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      st_q   <= st_d;
      prev_q <= prev_d;
      rc_q   <= rc_d;
      ri_q   <= ri_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      byte_q <= byte_d;
      perr_q <= perr_d;
    end
  end

  assign done   = done_q;
  assign byte_o = byte_q;
  assign perr   = perr_q;

endmodule

// File: rtl/sc_framer.sv
module sc_framer
  import sc_framer_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby_i,
  input  logic       sample_tick_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       line_i,
  output logic       line_drive_low_o
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic          mode_msb, mode_inv, mode_en, par_odd;
  logic [DW-1:0] thr, rx_byte;
  logic          thr_full, tx_take, tx_busy, rx_done, rx_perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (standby_i),
    .we       (reg_we_i),
    .re       (reg_re_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .tx_take  (tx_take),
    .tx_busy  (tx_busy),
    .rx_done  (rx_done),
    .rx_byte  (rx_byte),
    .rx_perr  (rx_perr),
    .rdata    (reg_rdata_o),
    .msb      (mode_msb),
    .inv      (mode_inv),
    .en       (mode_en),
    .odd      (par_odd),
    .thr      (thr),
    .thr_full (thr_full)
  );

  sc_tx #(.OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (standby_i),
    .tick      (sample_tick_i),
    .en        (mode_en),
    .msb       (mode_msb),
    .inv       (mode_inv),
    .odd       (par_odd),
    .pend      (thr_full),
    .data      (thr),
    .take      (tx_take),
    .busy      (tx_busy),
    .drive_low (line_drive_low_o)
  );

  sc_rx #(.OVS(OVS)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (standby_i),
    .tick   (sample_tick_i),
    .active (mode_en & ~tx_busy),
    .line_i (line_i),
    .msb    (mode_msb),
    .inv    (mode_inv),
    .odd    (par_odd),
    .done   (rx_done),
    .byte_o (rx_byte),
    .perr   (rx_perr)
  );

endmodule

// File: rtl/sc_framer_chk.sv
module sc_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic       line_drive_low_o,
  input logic       tx_busy,
  input logic       mode_en
);

  // R2
  mode_fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[7:4] == 4'hF && reg_rdata_o[1]));

  // R4
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !line_drive_low_o);

  // R4
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> line_drive_low_o);

  // R11
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en && !tx_busy) |=> !tx_busy);

  // R3
  standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (!tx_busy && !mode_en));

endmodule

bind sc_framer sc_framer_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .standby_i        (standby_i),
  .reg_addr_i       (reg_addr_i),
  .reg_rdata_o      (reg_rdata_o),
  .line_drive_low_o (line_drive_low_o),
  .tx_busy          (tx_busy),
  .mode_en          (mode_en)
);

// File: tb/sc_framer_bench.sv
`timescale 1ns/1ps
module sc_framer_bench;

  localparam int OVS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_low = 1'b0;
  logic       drive_low;
  logic       line;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign line = ~(drive_low | ext_low);

  sc_framer #(.OVS(OVS)) u_sc_framer (
    .clk              (clk),
    .rst_n            (rst_n),
    .standby_i        (standby),
    .sample_tick_i    (tick),
    .reg_we_i         (we),
    .reg_re_i         (re),
    .reg_addr_i       (addr),
    .reg_wdata_i      (wdata),
    .reg_rdata_o      (rdata),
    .line_i           (line),
    .line_drive_low_o (drive_low)
  );

  always @(negedge clk) tick <= ~tick;

  // Behavioural transmit model
  bit       m_busy, m_pend, m_msb, m_inv, m_en, m_odd;
  bit [7:0] m_byte;
  int       m_cnt;
  bit       m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || standby) begin
      m_busy = 0; m_pend = 0; m_msb = 0; m_inv = 0; m_en = 0; m_odd = 0;
      m_byte = 0; m_cnt = 0; m_q.delete();
    end else begin
      if (m_busy) begin
        if (tick) begin
          m_cnt++;
          if (m_cnt == OVS) begin
            void'(m_q.pop_front());
            m_cnt = 0;
            if (m_q.size() == 0) m_busy = 0;
          end
        end
      end else if (tick && m_pend && m_en) begin
        bit [7:0] v;
        v = m_inv ? ~m_byte : m_byte;
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(m_msb ? v[7-i] : v[i]);
        m_q.push_back((^m_byte) ^ m_odd);
        m_busy = 1; m_cnt = 0; m_pend = 0;
      end
      if (we) begin
        case (addr)
          2'd0: begin m_msb = wdata[3]; m_inv = wdata[2]; m_en = wdata[0]; end
          2'd1: begin m_byte = wdata; m_pend = 1; end
          2'd3: m_odd = wdata[0];
          default: ;
        endcase
      end
    end
  end

  // Per-clock line comparison (R4, R5, R6, R7, R10, R11)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_low;
      exp_low = m_busy && (m_q.size() > 0) && (m_q[0] == 1'b0);
      n_cmp++;
      if (drive_low !== exp_low) begin
        n_bad++;
        $display("FAIL R4 line at %0t: got %0b expected %0b", $time, drive_low, exp_low);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] mask,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1;
    n_cmp++;
    if ((rdata & mask) !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, rdata & mask, exp);
    end
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_tx_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!m_busy && !m_pend) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // Drive a receive frame whose register-side value is b
  task automatic send_rx(input logic [7:0] b, input bit msb, input bit inv,
                         input bit odd, input bit bad_par);
    logic [7:0] v;
    logic [9:0] bits;
    v = inv ? ~b : b;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = msb ? v[7-i] : v[i];
    bits[9] = (^b) ^ odd ^ bad_par;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      ext_low = ~bits[i];
      repeat (2 * OVS) @(negedge clk);
    end
    ext_low = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, 8'hFF, 8'hF2, "R1 mode after reset");
    rd(2'd3, 8'h1F, 8'h00, "R1 status after reset");

    // R2 fixed and writable mode bits
    wr(2'd0, 8'h00); rd(2'd0, 8'hFF, 8'hF2, "R2 write 00");
    wr(2'd0, 8'h0D); rd(2'd0, 8'hFF, 8'hFF, "R2 write 0D");
    wr(2'd0, 8'hF4); rd(2'd0, 8'hFF, 8'hF6, "R2 write F4");

    // R4 R5 R7 R10: LSB first, even parity, held second byte
    wr(2'd0, 8'h01); wr(2'd3, 8'h00);
    wr(2'd1, 8'hA5);
    repeat (6) @(negedge clk);
    wr(2'd1, 8'h3C);
    rd(2'd3, 8'h18, 8'h18, "R10 busy with byte held");
    wait_tx_idle();
    rd(2'd3, 8'h18, 8'h00, "R10 held byte sent");

    // R5 MSB first
    wr(2'd0, 8'h09); wr(2'd1, 8'h81); wait_tx_idle();
    // R6 R7 invert with odd parity
    wr(2'd0, 8'h05); wr(2'd3, 8'h01); wr(2'd1, 8'h0F); wait_tx_idle();
    // R5 R6 both
    wr(2'd0, 8'h0D); wr(2'd3, 8'h00); wr(2'd1, 8'h6E); wait_tx_idle();

    // R11 disabled: byte stays held
    wr(2'd0, 8'h00); wr(2'd1, 8'h55);
    repeat (100) @(negedge clk);
    rd(2'd3, 8'h18, 8'h10, "R11 held while disabled");
    wr(2'd0, 8'h01); wait_tx_idle();
    rd(2'd3, 8'h18, 8'h00, "R11 sent after enable");

    // R8 receive LSB first, even parity
    send_rx(8'h5A, 0, 0, 0, 0);
    rd(2'd3, 8'h06, 8'h04, "R8 rx valid, R9 parity ok");
    rd(2'd2, 8'hFF, 8'h5A, "R8 rx byte");
    rd(2'd3, 8'h04, 8'h00, "R8 valid cleared by read");

    // R9 bad parity
    send_rx(8'h33, 0, 0, 0, 1);
    rd(2'd3, 8'h06, 8'h06, "R9 parity error");
    rd(2'd2, 8'hFF, 8'h33, "R9 rx byte with bad parity");

    // R5 R6 R7 receive MSB first, inverted, odd parity
    wr(2'd0, 8'h0D); wr(2'd3, 8'h01);
    send_rx(8'hC4, 1, 1, 1, 0);
    rd(2'd3, 8'h06, 8'h04, "R7 parity not inverted");
    rd(2'd2, 8'hFF, 8'hC4, "R5 R6 rx msb inverted");

    // R6 inversion only
    wr(2'd0, 8'h05); wr(2'd3, 8'h00);
    send_rx(8'h17, 0, 1, 0, 0);
    rd(2'd3, 8'h06, 8'h04, "R6 rx inverted parity ok");
    rd(2'd2, 8'hFF, 8'h17, "R6 rx inverted byte");

    // R11 receiver ignores line when disabled
    wr(2'd0, 8'h00);
    send_rx(8'h99, 0, 0, 0, 0);
    rd(2'd3, 8'h04, 8'h00, "R11 rx ignored when disabled");

    // R3 standby
    wr(2'd0, 8'h0D); wr(2'd3, 8'h01); wr(2'd1, 8'h42);
    repeat (10) @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    rd(2'd0, 8'hFF, 8'hF2, "R3 mode after standby");
    rd(2'd3, 8'h1F, 8'h00, "R3 status after standby");
    repeat (100) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule